// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a parallel NOR flash. After the host has sent a program or erase command sequence, it pulses `start_i`. With that pulse it gives the operation kind, the byte that was last written (used for a program only), a polling mode and a limit on read attempts. The block then reads the status byte from the device again and again over a request/acknowledge handshake. It stops when the operation is seen to be finished, or when the read budget runs out.

There are two completion tests, and the mode picks which ones count:

- **Bit-7 test.** It compares bit 7 of the read byte with the value expected at completion. For a program, that value is bit 7 of the written byte, because the device returns its complement while busy. For an erase, the value is 1, because the device returns 0 while busy.
- **Bit-6 test.** It declares the operation stable once two back-to-back reads of the same operation return the same bit 6, since the device flips that bit on every read while busy.

The result is a one-cycle `done_o` pulse, with `error_o` set alongside it when the limit was reached.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `busy_o`, `done_o`, `error_o` and `rd_req_o` are all 0.
- R2: A `start_i` pulse in idle captures its inputs. In the following cycle, `busy_o` and `rd_req_o` are both 1.
- R3: `rd_req_o` stays at 1 until the operation ends. Each cycle with `rd_req_o` and `rd_ack_i` both high is one read, and `rd_data_i` is sampled in that cycle.
- R4: Mode 0 (bit-7 only) finishes on the first read whose bit 7 equals the expected value. That value is `exp_data_i[7]` when `op_erase_i` is 0, and 1 when `op_erase_i` is 1.
- R5: Mode 1 (bit-6 only) finishes on the first read whose bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation never finishes in this mode.
- R6: Modes 2 and 3 finish only on a read that passes both the R4 test and the R5 test.
- R7: Completion gives a `done_o` pulse of exactly one cycle, in the cycle after the finishing read. `error_o` is 0 in that cycle, and no further read is requested.
- R8: With a limit L = max(`limit_i`, 1), if read number L does not finish the operation, `done_o` and `error_o` are both 1 for one cycle and the block returns to idle.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored: the result and the read count follow the first start only.
- R10: `busy_o` is 1 from the cycle after an accepted start up to the cycle before `done_o`. It is 0 whenever `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only in idle |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program |
| exp_data_i | input | 8 | Last byte written (program) |
| mode_i | input | 2 | 0 bit-7 test, 1 bit-6 test, 2/3 both |
| limit_i | input | LIMIT_W | Maximum read attempts (0 acts as 1) |
| rd_req_o | output | 1 | Read request to the flash interface |
| rd_ack_i | input | 1 | Read acknowledge; data valid this cycle |
| rd_data_i | input | 8 | Status byte returned by the read |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| error_o | output | 1 | Set with `done_o` on timeout |

## Verification
The bench builds the block with `LIMIT_W = 6`, so read limits run from 0 to 63. A simulated device stays busy for up to 70 reads, which means both a timeout and a normal finish occur within a short run. This small width also brings the limit-of-zero case and a limit hit exactly on the finishing read within reach. In the latter case, completion must win over timeout.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        PM_BIT7   = 2'd0,
        PM_BIT6   = 2'd1,
        PM_BOTH   = 2'd2,
        PM_BOTH_X = 2'd3
    } poll_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } poll_state_e;
endpackage

// File: rtl/poll_judge.sv
module poll_judge
    import poll_pkg::*;
(
    input  poll_mode_e  mode,
    input  logic        exp7,
    input  logic        have_prev,
    input  logic        prev6,
    input  logic [7:0]  data,
    output logic        finished
);
    logic bit7_ok;
    logic bit6_steady;

    always_comb begin
        bit7_ok     = (data[7] == exp7);
        bit6_steady = have_prev && (data[6] == prev6);
        unique case (mode)
            PM_BIT7: finished = bit7_ok;
            PM_BIT6: finished = bit6_steady;
            default: finished = bit7_ok && bit6_steady;
        endcase
    end
endmodule

// File: rtl/attempt_counter.sv
module attempt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    localparam int CW = W + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)    cnt_d = '0;
        else if (inc) cnt_d = cnt_q + CW'(1);
        last = ((cnt_q + CW'(1)) >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import poll_pkg::*;
#(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               op_erase_i,
    input  logic [7:0]         exp_data_i,
    input  logic [1:0]         mode_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               rd_req_o,
    input  logic               rd_ack_i,
    input  logic [7:0]         rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o
);
    typedef struct packed {
        poll_state_e        st;
        logic               exp7;
        poll_mode_e         mode;
        logic [LIMIT_W-1:0] lim;
        logic               have_prev;
        logic               prev6;
        logic               done;
        logic               err;
    } regs_t;

    regs_t r_d, r_q;
    logic  cnt_clear, cnt_inc, cnt_last;
    logic  finished;

    poll_judge u_judge (
        .mode      (r_q.mode),
        .exp7      (r_q.exp7),
        .have_prev (r_q.have_prev),
        .prev6     (r_q.prev6),
        .data      (rd_data_i),
        .finished  (finished)
    );

    attempt_counter #(.W(LIMIT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .limit (r_q.lim),
        .last  (cnt_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_POLL;
                    r_d.exp7      = op_erase_i ? 1'b1 : exp_data_i[7];
                    r_d.mode      = poll_mode_e'(mode_i);
                    r_d.lim       = limit_i;
                    r_d.have_prev = 1'b0;
                    r_d.prev6     = 1'b0;
                    cnt_clear     = 1'b1;
                end
            end
            default: begin
                if (rd_ack_i) begin
                    cnt_inc       = 1'b1;
                    r_d.have_prev = 1'b1;
                    r_d.prev6     = rd_data_i[6];
                    if (finished) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else if (cnt_last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: PM_BIT7, lim: '0, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o = (r_q.st == ST_POLL);
    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign error_o  = r_q.err;
endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
    parameter int LIMIT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [LIMIT_W-1:0] limit_i,
    input logic               rd_req_o,
    input logic               rd_ack_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               error_o
);
    logic [LIMIT_W:0]   acks_q;
    logic [LIMIT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks_q <= '0;
            lim_q  <= '0;
        end else if (!busy_o && start_i) begin
            acks_q <= '0;
            lim_q  <= limit_i;
        end else if (rd_req_o && rd_ack_i) begin
            acks_q <= acks_q + 1'b1;
        end
    end

    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_req_o && rd_ack_i));
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);
    assert_timeout_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o) |-> (acks_q == ((lim_q == '0) ? (LIMIT_W+1)'(1) : {1'b0, lim_q})));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !rd_ack_i) |=> busy_o);
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    assert_idle_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind flash_done_poller poll_checker #(.LIMIT_W(LIMIT_W)) u_poll_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .limit_i  (limit_i),
    .rd_req_o (rd_req_o),
    .rd_ack_i (rd_ack_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .error_o  (error_o)
);

// File: tb/flash_done_poller_bench.sv
`timescale 1ns/1ps
module flash_done_poller_bench;
    localparam int LW   = 6;
    localparam int MAXR = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic [7:0]    exp_data_i = '0;
    logic [1:0]    mode_i = '0;
    logic [LW-1:0] limit_i = '0;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          rd_req_o, busy_o, done_o, error_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [7:0] dev [1:MAXR];

    always #2.5 clk = ~clk;

    flash_done_poller #(.LIMIT_W(LW)) u_flash_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .exp_data_i(exp_data_i), .mode_i(mode_i), .limit_i(limit_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit finishes(input int k, input bit exp7, input int mode);
        bit b7, b6;
        b7 = (dev[k][7] == exp7);
        b6 = (k > 1) && (dev[k][6] == dev[k-1][6]);
        if (mode == 0) return b7;
        if (mode == 1) return b6;
        return b7 && b6;
    endfunction

    task automatic run_op(input bit erase, input logic [7:0] wr, input int mode,
                          input int lim, input int busy_n, input bit poke);
        bit   exp7, got_done, got_err;
        bit   ph;
        int   first, exp_reads, reads, lmt;
        exp7 = erase ? 1'b1 : wr[7];
        ph   = 1'($urandom);
        for (int k = 1; k <= MAXR; k++) begin
            if (k <= busy_n) begin
                dev[k]    = 8'($urandom);
                dev[k][7] = erase ? 1'b0 : ~wr[7];
                dev[k][6] = ph ^ k[0];
            end else begin
                dev[k] = erase ? 8'hFF : wr;
            end
        end
        first = MAXR + 1;
        for (int k = MAXR; k >= 1; k--) if (finishes(k, exp7, mode)) first = k;
        lmt       = (lim == 0) ? 1 : lim;
        exp_reads = (first < lmt) ? first : lmt;

        @(negedge clk);
        start_i = 1'b1; op_erase_i = erase; exp_data_i = wr;
        mode_i = 2'(mode); limit_i = LW'(lim);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", int'(busy_o), 1);
        check("R2 rd_req after start", int'(rd_req_o), 1);
        reads = 0; got_done = 0; got_err = 0;
        while (!got_done && reads < MAXR + 5) begin
            if ($urandom_range(0, 2) == 0) begin
                @(negedge clk);
                if (done_o) begin got_done = 1; got_err = error_o; end
            end else begin
                if (!rd_req_o) begin
                    check("R3 rd_req held while polling", 0, 1);
                    break;
                end
                rd_ack_i  = 1'b1;
                rd_data_i = dev[reads + 1];
                if (poke && reads == 1) begin
                    start_i = 1'b1; mode_i = 2'(mode ^ 1); op_erase_i = ~erase;
                    exp_data_i = ~wr; limit_i = '1;
                end
                @(negedge clk);
                rd_ack_i = 1'b0; start_i = 1'b0;
                reads++;
                if (done_o) begin
                    got_done = 1; got_err = error_o;
                    check("R10 busy low with done", int'(busy_o), 0);
                end
            end
        end
        if (poke) check("R9 read count ignores busy start", reads, exp_reads);
        else if (first <= lmt) check("R4 R5 R6 reads to completion", reads, exp_reads);
        else check("R8 reads before timeout", reads, exp_reads);
        check("R7 done seen", int'(got_done), 1);
        check("R8 error flag", int'(got_err), (first > lmt) ? 1 : 0);
        @(negedge clk);
        check("R7 done is one cycle", int'(done_o), 0);
        check("R7 no read after done", int'(rd_req_o), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 req in reset", int'(rd_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done_o), 0);
        check("R1 error after reset", int'(error_o), 0);

        run_op(0, 8'hA5, 0, 10, 0, 0);   // R4 program done on first read
        run_op(0, 8'h35, 0, 10, 4, 0);   // R4 program bit7 low
        run_op(1, 8'h00, 0, 20, 6, 0);   // R4 erase
        run_op(0, 8'h80, 1, 10, 0, 0);   // R5 first read never finishes
        run_op(1, 8'h00, 1, 20, 7, 0);   // R5 toggle
        run_op(0, 8'hC3, 2, 20, 5, 0);   // R6 both
        run_op(1, 8'h00, 3, 20, 3, 0);   // R6 mode 3
        run_op(0, 8'h11, 0, 0, 5, 0);    // R8 limit zero acts as one
        run_op(1, 8'h00, 0, 4, 10, 0);   // R8 timeout
        run_op(0, 8'h7E, 0, 5, 4, 0);    // R8 finish on last allowed read
        run_op(0, 8'h5A, 0, 30, 8, 1);   // R9 start while busy
        for (int i = 0; i < 40; i++)
            run_op(1'($urandom), 8'($urandom), $urandom_range(0, 3),
                   $urandom_range(0, 63), $urandom_range(0, 70), 1'($urandom_range(0, 4) == 0));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule